// File: doc/BRIEF.md
# Hot-swap power-up sequencer

This block is the digital control core of a hot-swap card. It takes comparator outcomes that have already been digitized: supply above its low limit, supply below its high limit, switch drain low, and gate at its turn-on threshold. It also takes the card-seated contacts, a master enable, a trip request from a separate protection block, and two enables for the downstream power rails. From these it drives a gate enable for the external pass switch and three cascaded power-good enables for downstream converters. All outputs are active high. The conversion to active-low open-drain pins happens outside the block.

A state machine with three states runs the block. In QUALIFY the start conditions must hold without a break for `QUAL_CYC` cycles; the transition *qualified* then moves it to RAMP and turns the gate on. In RAMP the block remembers that the gate reached its threshold, even if the gate later drops below it. When that memory is set and the drain reads low, the transition *switch on* moves it to GOOD, where power-good 1 is raised. A chain of delay stages then raises power-good 2 and power-good 3, each `PG_CYC` cycles after the one before it. The transition *abort* returns RAMP or GOOD to QUALIFY. It fires on loss of any start condition, or on a drain failure in GOOD while current regulation is inactive. On an abort every output drops in the same cycle, the threshold memory is cleared, and qualification starts over.

Top module: `hs_power_sequencer`

## Requirements
- R1: `gate_en` (1 = on) stays 0 until the start condition has been sampled true on `QUAL_CYC` consecutive rising edges, and becomes 1 after the next rising edge. The start condition is `uv_ok`=1, `ov_ok`=1, `pd1_n`=0, `pd2_n`=0, `master_en`=1 and `prot_trip`=0.
- R2: When any single part of the start condition is lost while powered, `gate_en` and every power-good output go to 0 in the same cycle, without waiting for a clock edge.
- R3: In RAMP, `pg1_en` becomes 1 at the first rising edge where the gate threshold has been seen and `drain_low`=1. The threshold counts as seen if `gate_at_thr` is 1 now or was 1 at any earlier edge in this RAMP.
- R4: `pg2_en` becomes 1 exactly `PG_CYC` rising edges after `pg1_en` rose, provided `pg_en_a`=1 throughout.
- R5: `pg3_en` becomes 1 exactly `PG_CYC` rising edges after `pg2_en` rose, provided `pg_en_a`=1 and `pg_en_b`=1 throughout.
- R6: Setting `pg_en_a` to 0 clears `pg2_en` and `pg3_en` at once. Setting `pg_en_b` to 0 clears only `pg3_en`. Once the enable returns, the affected stage counts its full delay again.
- R7: While `rst_n`=0 all outputs are 0, even in the middle of a powered sequence.
- R8: In GOOD, `drain_low`=0 causes an abort (all outputs 0 at once) unless `cur_reg_active`=1, in which case it is ignored.
- R9: After an abort the block requalifies for the full `QUAL_CYC` window. The threshold memory is cleared, so `pg1_en` needs a new `gate_at_thr`=1.
- R10: If the start condition breaks during qualification, the qualification count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; forces all outputs off |
| uv_ok | input | 1 | Supply above low limit |
| ov_ok | input | 1 | Supply below high limit |
| pd1_n | input | 1 | Seated contact 1, active low |
| pd2_n | input | 1 | Seated contact 2, active low |
| master_en | input | 1 | Master enable |
| prot_trip | input | 1 | Shutdown request from the protection block |
| gate_at_thr | input | 1 | Gate has reached its full-on threshold |
| drain_low | input | 1 | Switch drain below its limit |
| cur_reg_active | input | 1 | Current regulation in progress; masks drain check |
| pg_en_a | input | 1 | Enable for power-good 2 and 3 |
| pg_en_b | input | 1 | Enable for power-good 3 |
| gate_en | output | 1 | Pass switch gate enable |
| pg1_en | output | 1 | Power-good 1 |
| pg2_en | output | 1 | Power-good 2 |
| pg3_en | output | 1 | Power-good 3 |

## Verification
The bench breaks qualification one cycle short of the window. A design that did not restart its counter would then turn the gate on early. It pulses the gate threshold only while the drain is still high, to catch a design that samples the threshold instead of remembering it; such a design would never raise power-good 1. It drops each enable by itself in steady state and expects the outputs to fall without a clock edge and the delay to rerun in full. A stuck stage or a wrong cascade would leave a rail on, or bring it back early. Random stimulus from a fixed seed is compared cycle by cycle with a model in the bench, including drain failures that current regulation masks and that it does not.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;
    typedef enum logic [1:0] {
        ST_QUALIFY = 2'd0,
        ST_RAMP    = 2'd1,
        ST_GOOD    = 2'd2
    } seq_state_t;
endpackage

// File: rtl/hs_start_qual.sv
module hs_start_qual (
    input  logic uv_ok,
    input  logic ov_ok,
    input  logic pd1_n,
    input  logic pd2_n,
    input  logic master_en,
    input  logic prot_trip,
    output logic start_ok
);
    logic supply_in_window;
    logic card_seated;

    assign supply_in_window = uv_ok & ov_ok;
    assign card_seated      = ~pd1_n & ~pd2_n;
    assign start_ok         = supply_in_window & card_seated & master_en & ~prot_trip;
endmodule

// File: rtl/hs_delay_stage.sv
module hs_delay_stage #(
    parameter int unsigned DLY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done_o
);
    localparam int unsigned CW   = (DLY < 2) ? 1 : $clog2(DLY);
    localparam logic [CW-1:0] LAST = CW'(DLY - 1);

    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!start) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done_o = done_q & start;

    // R4 / R5 / R10: a release only ever follows a full count
    assert_full_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/hs_pg_cascade.sv
module hs_pg_cascade #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned DLY    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [STAGES-1:0] stage_en,
    output logic [STAGES-1:0] stage_on
);
    logic [STAGES:0] chain;

    assign chain[0] = run;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic arm;
        assign arm = chain[i] & stage_en[i];

        hs_delay_stage #(.DLY(DLY)) u_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (arm),
            .done_o (chain[i+1])
        );

        // R5: a later rail is never on without the one before it and its own enable
        assert_cascade_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
            chain[i+1] |-> (chain[i] && stage_en[i]));
    end

    assign stage_on = chain[STAGES:1];
endmodule

// File: rtl/hs_power_sequencer.sv
module hs_power_sequencer #(
    parameter int unsigned QUAL_CYC = 1000,
    parameter int unsigned PG_CYC   = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_ok,
    input  logic ov_ok,
    input  logic pd1_n,
    input  logic pd2_n,
    input  logic master_en,
    input  logic prot_trip,
    input  logic gate_at_thr,
    input  logic drain_low,
    input  logic cur_reg_active,
    input  logic pg_en_a,
    input  logic pg_en_b,
    output logic gate_en,
    output logic pg1_en,
    output logic pg2_en,
    output logic pg3_en
);
    import hs_seq_pkg::*;

    localparam int unsigned PG_STAGES = 2;

    seq_state_t st_q, st_d;
    logic start_ok;
    logic qual_arm, qual_done;
    logic thr_q, thr_seen;
    logic drain_fail, abort;
    logic gate_c, pg1_c;
    logic [PG_STAGES-1:0] tail_en, tail_on;

    hs_start_qual u_cond (
        .uv_ok     (uv_ok),
        .ov_ok     (ov_ok),
        .pd1_n     (pd1_n),
        .pd2_n     (pd2_n),
        .master_en (master_en),
        .prot_trip (prot_trip),
        .start_ok  (start_ok)
    );

    assign qual_arm = start_ok && (st_q == ST_QUALIFY);

    hs_delay_stage #(.DLY(QUAL_CYC)) u_qual_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (qual_arm),
        .done_o (qual_done)
    );

    assign thr_seen   = thr_q | gate_at_thr;
    assign drain_fail = (st_q == ST_GOOD) && !drain_low && !cur_reg_active;
    assign abort      = !start_ok || drain_fail;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_QUALIFY;
        end else begin
            st_q <= st_d;
        end
    end

    // gate threshold memory, cleared whenever the sequence falls back
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= 1'b0;
        end else if ((st_q == ST_QUALIFY) || abort) begin
            thr_q <= 1'b0;
        end else if ((st_q == ST_RAMP) && gate_at_thr) begin
            thr_q <= 1'b1;
        end
    end

    // transitions: qualified, switch on, abort
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUALIFY: if (qual_done)                    st_d = ST_RAMP;
            ST_RAMP: begin
                if (abort)                                st_d = ST_QUALIFY;
                else if (thr_seen && drain_low)           st_d = ST_GOOD;
            end
            ST_GOOD:    if (abort)                        st_d = ST_QUALIFY;
            default:                                      st_d = ST_QUALIFY;
        endcase
    end

    // outputs
    always_comb begin
        gate_c = 1'b0;
        pg1_c  = 1'b0;
        unique case (st_q)
            ST_QUALIFY: ;
            ST_RAMP:    gate_c = !abort;
            ST_GOOD: begin
                gate_c = !abort;
                pg1_c  = !abort;
            end
            default: ;
        endcase
    end

    assign tail_en = {pg_en_b, pg_en_a};

    hs_pg_cascade #(.STAGES(PG_STAGES), .DLY(PG_CYC)) u_tail (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pg1_c),
        .stage_en (tail_en),
        .stage_on (tail_on)
    );

    assign gate_en = gate_c;
    assign pg1_en  = pg1_c;
    assign pg2_en  = tail_on[0];
    assign pg3_en  = tail_on[1];

    // R1: the gate comes on only out of a completed qualification
    assert_gate_from_qualify_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> ($past(st_q) == ST_QUALIFY && $past(start_ok)));

    // R3: power-good 1 rises only with the drain low and the threshold seen
    assert_pg1_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg1_en) |-> ($past(drain_low) && ($past(thr_q) || $past(gate_at_thr))));

    // R4: power-good 2 implies power-good 1 and the gate
    assert_pg2_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pg2_en |-> (pg1_en && gate_en));

    // R9: a fresh ramp never inherits a remembered threshold
    assert_thr_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RAMP && $past(st_q) == ST_QUALIFY) |-> !thr_q);
endmodule

// File: tb/test_hs_power_sequencer.sv
`timescale 1ns/1ps
module test_hs_power_sequencer;
    localparam int QC = 6;
    localparam int PC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_ok, ov_ok, pd1_n, pd2_n, master_en, prot_trip;
    logic gate_at_thr, drain_low, cur_reg_active, pg_en_a, pg_en_b;
    logic gate_en, pg1_en, pg2_en, pg3_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit rnd_on = 0;

    always #4 clk = ~clk;

    hs_power_sequencer #(.QUAL_CYC(QC), .PG_CYC(PC)) i_hs_power_sequencer (
        .clk(clk), .rst_n(rst_n), .uv_ok(uv_ok), .ov_ok(ov_ok), .pd1_n(pd1_n),
        .pd2_n(pd2_n), .master_en(master_en), .prot_trip(prot_trip),
        .gate_at_thr(gate_at_thr), .drain_low(drain_low),
        .cur_reg_active(cur_reg_active), .pg_en_a(pg_en_a), .pg_en_b(pg_en_b),
        .gate_en(gate_en), .pg1_en(pg1_en), .pg2_en(pg2_en), .pg3_en(pg3_en)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_good();
        uv_ok = 1; ov_ok = 1; pd1_n = 0; pd2_n = 0; master_en = 1; prot_trip = 0;
    endtask

    // ---------------- reference model (from the requirements) ----------------
    int  m_st, m_qc, m_c2, m_c3;
    bit  m_qd, m_thr, m_d2, m_d3;

    function automatic bit f_start();
        return uv_ok && ov_ok && !pd1_n && !pd2_n && master_en && !prot_trip;
    endfunction

    function automatic bit f_abort();
        return !f_start() || (m_st == 2 && !drain_low && !cur_reg_active);
    endfunction

    function automatic logic [3:0] f_expect();
        bit g, p1, p2, p3;
        g  = (m_st != 0) && !f_abort();
        p1 = (m_st == 2) && !f_abort();
        p2 = m_d2 && p1 && pg_en_a;
        p3 = m_d3 && p2 && pg_en_b;
        return {g, p1, p2, p3};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_qc = 0; m_c2 = 0; m_c3 = 0;
            m_qd = 0; m_thr = 0; m_d2 = 0; m_d3 = 0;
        end else begin
            bit ok, ab, s2, s3, qd_now;
            logic [3:0] e;
            ok = f_start();
            ab = f_abort();
            e  = f_expect();
            s2 = e[2] && pg_en_a;
            s3 = e[1] && pg_en_b;
            qd_now = m_qd;
            if (!(ok && m_st == 0)) begin m_qc = 0; m_qd = 0; end
            else if (!m_qd) begin if (m_qc == QC - 1) m_qd = 1; else m_qc++; end
            if (!s2) begin m_c2 = 0; m_d2 = 0; end
            else if (!m_d2) begin if (m_c2 == PC - 1) m_d2 = 1; else m_c2++; end
            if (!s3) begin m_c3 = 0; m_d3 = 0; end
            else if (!m_d3) begin if (m_c3 == PC - 1) m_d3 = 1; else m_c3++; end
            case (m_st)
                0: begin if (qd_now && ok) m_st = 1; m_thr = 0; end
                1: begin
                    if (ab) begin m_st = 0; m_thr = 0; end
                    else begin
                        if ((m_thr || gate_at_thr) && drain_low) m_st = 2;
                        if (gate_at_thr) m_thr = 1;
                    end
                end
                default: if (ab) begin m_st = 0; m_thr = 0; end
            endcase
        end
    end

    always @(negedge clk) begin
        if (rnd_on) begin
            logic [3:0] e;
            e = f_expect();
            chk("R1 gate_en vs model", gate_en, e[3]);
            chk("R3 pg1_en vs model", pg1_en, e[2]);
            chk("R4 pg2_en vs model", pg2_en, e[1]);
            chk("R5 pg3_en vs model", pg3_en, e[0]);
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- directed and random stimulus ----------------
    initial begin
        void'($urandom(32'h0000_5eed));
        set_good();
        master_en = 0;
        gate_at_thr = 0; drain_low = 0; cur_reg_active = 0;
        pg_en_a = 1; pg_en_b = 1;
        tick(3);
        chk("R7 reset gate", gate_en, 1'b0);
        chk("R7 reset pg1", pg1_en, 1'b0);
        rst_n = 1;

        // R10: break one cycle short, then full window for R1
        master_en = 1;
        tick(QC - 1);
        chk("R10 early gate", gate_en, 1'b0);
        master_en = 0;
        tick(1);
        master_en = 1;
        tick(QC);
        chk("R10 restarted window", gate_en, 1'b0);
        tick(1);
        chk("R1 gate after window", gate_en, 1'b1);

        // R3: threshold seen while drain still high, remembered
        tick(3);
        chk("R3 no threshold yet", pg1_en, 1'b0);
        gate_at_thr = 1;
        tick(1);
        gate_at_thr = 0;
        tick(2);
        chk("R3 drain still high", pg1_en, 1'b0);
        drain_low = 1;
        #1 chk("R3 waits for edge", pg1_en, 1'b0);
        tick(1);
        chk("R3 pg1 from remembered threshold", pg1_en, 1'b1);
        tick(PC - 1);
        chk("R4 pg2 early", pg2_en, 1'b0);
        tick(1);
        chk("R4 pg2 on time", pg2_en, 1'b1);
        tick(PC - 1);
        chk("R5 pg3 early", pg3_en, 1'b0);
        tick(1);
        chk("R5 pg3 on time", pg3_en, 1'b1);

        // R6: enable B alone, then enable A
        pg_en_b = 0;
        #1 chk("R6 B low drops pg3", pg3_en, 1'b0);
        chk("R6 B low keeps pg2", pg2_en, 1'b1);
        tick(1);
        pg_en_b = 1;
        tick(PC - 1);
        chk("R6 pg3 recount early", pg3_en, 1'b0);
        tick(1);
        chk("R6 pg3 recount done", pg3_en, 1'b1);
        pg_en_a = 0;
        #1 chk("R6 A low drops pg2", pg2_en, 1'b0);
        chk("R6 A low drops pg3", pg3_en, 1'b0);
        chk("R6 A low keeps pg1", pg1_en, 1'b1);
        tick(1);
        pg_en_a = 1;
        tick(PC);
        chk("R6 pg2 back", pg2_en, 1'b1);
        tick(PC);
        chk("R6 pg3 back", pg3_en, 1'b1);

        // R8: drain failure masked, then unmasked
        cur_reg_active = 1; drain_low = 0;
        #1 chk("R8 masked keeps pg1", pg1_en, 1'b1);
        tick(2);
        chk("R8 masked keeps pg3", pg3_en, 1'b1);
        cur_reg_active = 0;
        #1 chk("R8 drain fail gate", gate_en, 1'b0);
        chk("R8 drain fail pg1", pg1_en, 1'b0);
        tick(1);
        drain_low = 1;

        // R9: full requalification and cleared threshold memory
        tick(QC);
        chk("R9 requalify early", gate_en, 1'b0);
        tick(1);
        chk("R9 requalify done", gate_en, 1'b1);
        tick(3);
        chk("R9 threshold forgotten", pg1_en, 1'b0);
        gate_at_thr = 1;
        tick(1);
        chk("R9 pg1 with new threshold", pg1_en, 1'b1);

        // R2: each start condition lost on its own
        for (int i = 0; i < 6; i++) begin
            case (i)
                0: uv_ok = 0;
                1: ov_ok = 0;
                2: pd1_n = 1;
                3: pd2_n = 1;
                4: master_en = 0;
                default: prot_trip = 1;
            endcase
            #1 chk("R2 loss drops gate", gate_en, 1'b0);
            chk("R2 loss drops pg1", pg1_en, 1'b0);
            tick(1);
            chk("R2 still off", gate_en, 1'b0);
            set_good();
            tick(QC + 1);
            chk("R2 gate back", gate_en, 1'b1);
            tick(1);
            chk("R2 pg1 back", pg1_en, 1'b1);
        end

        // R7: reset in the middle of a powered sequence
        tick(2 * PC);
        rst_n = 0;
        #1 chk("R7 mid reset gate", gate_en, 1'b0);
        chk("R7 mid reset pg3", pg3_en, 1'b0);
        tick(2);
        rst_n = 1;

        // random phase against the model
        rnd_on = 1;
        for (int n = 0; n < 4000; n++) begin
            #1;
            if ($urandom % 24 == 0) uv_ok = ($urandom % 8) != 0;
            if ($urandom % 24 == 0) ov_ok = ($urandom % 8) != 0;
            if ($urandom % 24 == 0) pd1_n = ($urandom % 8) == 0;
            if ($urandom % 24 == 0) pd2_n = ($urandom % 8) == 0;
            if ($urandom % 24 == 0) master_en = ($urandom % 8) != 0;
            if ($urandom % 24 == 0) prot_trip = ($urandom % 8) == 0;
            if ($urandom % 6 == 0) gate_at_thr = ($urandom % 3) == 0;
            if ($urandom % 8 == 0) drain_low = ($urandom % 5) != 0;
            if ($urandom % 8 == 0) cur_reg_active = ($urandom % 4) == 0;
            if ($urandom % 16 == 0) pg_en_a = ($urandom % 6) != 0;
            if ($urandom % 16 == 0) pg_en_b = ($urandom % 6) != 0;
            tick(1);
        end
        rnd_on = 0;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule